// File: doc/BRIEF.md
# Realignable Integer Clock Divider

This block divides a sampling clock by a whole ratio N from 1 to 8. Its main output is a clock-enable pulse that lasts one input cycle and repeats every N cycles. A second output is a divided waveform that is high for the first floor(N/2) cycles of each period. The block also drives an enable flag for a downstream duty-cycle stabilizer. That flag is forced active whenever the running ratio differs from 1, because the divided waveform is not 50% for odd ratios.

An external strobe returns the counter to its starting phase. Several copies that share a clock and a strobe therefore produce identical phases. A small configuration port, written with a single strobe, sets the ratio and chooses how the strobe acts. The strobe can be ignored (the divider free-runs from reset), honoured on every rising edge, or honoured only on the first rising edge after each configuration write. A sticky flag reports that a one-shot realignment has taken place. A new ratio waits for the end of the current period, or for an accepted strobe, before it takes effect. This means no shortened period is ever produced.

Top module: `clkdiv_sync`

## Requirements
- R1: `cfg_ratio_m1` holds N-1, so the code values 0 to 7 select N = 1 to 8. `ce_out` is high for one cycle in every N cycles. When N = 1 it is high in every cycle.
- R2: Cycles of a period are numbered 0 to N-1 from the counter's starting phase. `div_out` is high in cycles 0 to floor(N/2)-1 and low in the rest, which keeps it low at all times when N = 1. `ce_out` is high in cycle N-1.
- R3: `dcs_en` equals the stored `cfg_dcs_req` bit OR'd with (running N ≠ 1).
- R4: `sync_in` passes through a two-flop synchronizer, and only its rising edge is a strobe event. Suppose `sync_in` rises before clock edge k and the event is accepted. Then the counter is in cycle 0 after edge k+2, and the next `ce_out` pulse follows N-1 cycles later.
- R5: With `cfg_sync_en` = 0, strobes have no effect and the counter keeps running from its reset phase.
- R6: With `cfg_sync_en` = 1 and `cfg_sync_once` = 0, every strobe event is accepted.
- R7: With `cfg_sync_en` = 1 and `cfg_sync_once` = 1, a configuration write arms the logic, and the first event accepted afterwards disarms it. Later events are ignored until the next write.
- R8: A newly written ratio is applied at the next counter wrap or the next accepted event, whichever comes first. The period that is running finishes at its old length.
- R9: `sync_seen` is set when an event is accepted in one-shot mode and cleared by the next configuration write.
- R10: Two instances that share a clock and `sync_in` and run the same ratio produce identical `ce_out` and `div_out` after an event both accept, whatever their earlier phases.
- R11: After reset the ratio is N = 1, the strobe is disabled, `ce_out` = 1, `div_out` = 0, `dcs_en` = 0 and `sync_seen` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock being divided |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ratio_m1 | input | 3 | Divide ratio minus one |
| cfg_sync_en | input | 1 | Allow strobe realignment |
| cfg_sync_once | input | 1 | Accept only the first strobe after a write |
| cfg_dcs_req | input | 1 | Stabilizer enable request for N = 1 |
| sync_in | input | 1 | Asynchronous realignment strobe |
| ce_out | output | 1 | Divided clock-enable pulse |
| div_out | output | 1 | Divided waveform |
| dcs_en | output | 1 | Stabilizer enable flag |
| sync_seen | output | 1 | Sticky one-shot acceptance flag |

## Verification
The checker tests several things on every cycle:
- The counter stays within the running ratio and steps by one unless it wraps or is restarted.
- Every accepted event restarts the counter.
- In one-shot mode an accepted event disarms the logic, and a write clears the sticky flag.
- Any ratio other than 1 forces the stabilizer flag, and ratio 1 holds the enable high with the waveform low.

Only the bench scenarios can show the remaining behaviours. These are the exact pulse and waveform patterns for each ratio, the cycle offset from a strobe to the first pulse, and the fact that strobes are ignored when disabled or once disarmed. They also include a ratio change that completes the old period first, and two dividers falling into step after a shared strobe.

// File: rtl/clkdiv_sync_pkg.sv
// Shared widths and the configuration record of the divider.
// Assumes the ratio range 1..8, so N-1 fits in three bits.
package clkdiv_sync_pkg;
    localparam int unsigned RATIO_W = 3;

    typedef struct packed {
        logic [RATIO_W-1:0] ratio_m1;
        logic               sync_en;
        logic               sync_once;
        logic               dcs_req;
    } div_cfg_t;
endpackage

// File: rtl/clkdiv_sync_edge.sv
// Brings the asynchronous strobe into the clock domain through STAGES
// flops and flags each rising edge for one cycle.
// Assumes the strobe stays high for at least one clock cycle.
module clkdiv_sync_edge #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_in,
    output logic sync_evt
);
    logic [STAGES-1:0] chain;
    logic              last_q;

    // First stage samples the raw strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= 1'b0;
        else        chain[0] <= sync_in;
    end

    // Remaining synchronizer stages.
    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) chain[g] <= 1'b0;
            else        chain[g] <= chain[g-1];
        end
    end

    // Previous synchronized value, used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= chain[STAGES-1];
    end

    assign sync_evt = chain[STAGES-1] & ~last_q;
endmodule

// File: rtl/clkdiv_cfg.sv
// Holds the configuration record and decides whether a strobe event is
// accepted, following the disabled, every-edge and one-shot policies.
// Assumes a write and an event in the same cycle: the write wins the arm state.
module clkdiv_cfg
    import clkdiv_sync_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cfg_we,
    input  div_cfg_t cfg_d,
    input  logic     sync_evt,
    output div_cfg_t cfg_q,
    output logic     accept,
    output logic     armed,
    output logic     seen
);
    // Configuration storage, loaded on each write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_q <= '0;
        else if (cfg_we) cfg_q <= cfg_d;
    end

    // Arm on write, disarm and mark seen on a one-shot acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
            seen  <= 1'b0;
        end else if (cfg_we) begin
            armed <= 1'b1;
            seen  <= 1'b0;
        end else if (accept && cfg_q.sync_once) begin
            armed <= 1'b0;
            seen  <= 1'b1;
        end
    end

    // Acceptance policy.
    always_comb begin
        accept = sync_evt && cfg_q.sync_en && (!cfg_q.sync_once || armed);
    end
endmodule

// File: rtl/clkdiv_core.sv
// Phase counter of the divider. It holds the running ratio, loads a
// pending ratio only at a wrap or a restart, and decodes the enable
// pulse and the divided waveform.
// Assumes pend_m1 may change at any time; only wraps sample it.
module clkdiv_core #(
    parameter int unsigned W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pend_m1,
    input  logic         restart,
    output logic         ce,
    output logic         div,
    output logic [W-1:0] act_m1,
    output logic [W-1:0] cnt
);
    logic         wrap;
    logic [W:0]   half;

    // Phase counter and running ratio.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            act_m1 <= '0;
        end else if (restart || wrap) begin
            cnt    <= '0;
            act_m1 <= pend_m1;
        end else begin
            cnt    <= cnt + 1'b1;
        end
    end

    // Output decode from the running state.
    always_comb begin
        wrap = (cnt == act_m1);
        half = ({1'b0, act_m1} + 1'b1) >> 1;
        ce   = wrap;
        div  = ({1'b0, cnt} < half);
    end
endmodule

// File: rtl/clkdiv_sync.sv
// Top of the realignable integer clock divider: strobe synchronizer,
// configuration and acceptance logic, phase counter, stabilizer flag.
// Assumes one clock domain; sync_in may be asynchronous.
module clkdiv_sync
    import clkdiv_sync_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [RATIO_W-1:0] cfg_ratio_m1,
    input  logic               cfg_sync_en,
    input  logic               cfg_sync_once,
    input  logic               cfg_dcs_req,
    input  logic               sync_in,
    output logic               ce_out,
    output logic               div_out,
    output logic               dcs_en,
    output logic               sync_seen
);
    div_cfg_t           cfg_d;
    div_cfg_t           cfg_q;
    logic               sync_evt;
    logic               accept;
    logic               armed;
    logic [RATIO_W-1:0] act_m1;
    logic [RATIO_W-1:0] cnt;

    // Pack the configuration fields.
    always_comb begin
        cfg_d = '{ratio_m1: cfg_ratio_m1, sync_en: cfg_sync_en,
                  sync_once: cfg_sync_once, dcs_req: cfg_dcs_req};
    end

    clkdiv_sync_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .sync_evt(sync_evt)
    );

    clkdiv_cfg u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_d(cfg_d),
        .sync_evt(sync_evt), .cfg_q(cfg_q), .accept(accept),
        .armed(armed), .seen(sync_seen)
    );

    clkdiv_core #(.W(RATIO_W)) u_core (
        .clk(clk), .rst_n(rst_n), .pend_m1(cfg_q.ratio_m1),
        .restart(accept), .ce(ce_out), .div(div_out),
        .act_m1(act_m1), .cnt(cnt)
    );

    // Stabilizer flag: forced for any running ratio above one.
    always_comb begin
        dcs_en = cfg_q.dcs_req || (act_m1 != '0);
    end
endmodule

// File: rtl/clkdiv_sync_chk.sv
// Cycle-level properties of the divider, bound into every instance.
module clkdiv_sync_chk #(
    parameter int unsigned W = 3
) (
    input logic         clk,
    input logic         rst_n,
    input logic         accept,
    input logic         once,
    input logic         cfg_we,
    input logic         armed,
    input logic [W-1:0] cnt,
    input logic [W-1:0] act_m1,
    input logic         ce_out,
    input logic         div_out,
    input logic         dcs_en,
    input logic         sync_seen
);
    p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= act_m1);

    p_ce_ratio1_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (act_m1 == '0) |-> ce_out);

    p_div_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (act_m1 == '0) |-> !div_out);

    p_dcs_forced_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (act_m1 != '0) |-> dcs_en);

    p_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (cnt == '0));

    p_disarm_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && once && !cfg_we) |=> !armed);

    p_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!accept && cnt != act_m1) |=> (cnt == $past(cnt) + 1'b1));

    p_seen_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> !sync_seen);
endmodule

bind clkdiv_sync clkdiv_sync_chk #(.W(clkdiv_sync_pkg::RATIO_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .accept(accept), .once(cfg_q.sync_once),
    .cfg_we(cfg_we), .armed(armed), .cnt(cnt), .act_m1(act_m1),
    .ce_out(ce_out), .div_out(div_out), .dcs_en(dcs_en),
    .sync_seen(sync_seen)
);

// File: tb/clkdiv_sync_bench.sv
module clkdiv_sync_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0, cfg_we_b = 1'b0;
    logic [2:0] cfg_ratio_m1 = 3'd0;
    logic       cfg_sync_en = 1'b0, cfg_sync_once = 1'b0, cfg_dcs_req = 1'b0;
    logic       sync_in = 1'b0;
    logic       ce_out, div_out, dcs_en, sync_seen;
    logic       ce_b, div_b, dcs_b, seen_b;
    int         n_chk = 0;
    int         n_bad = 0;

    always #5 clk = ~clk;

    clkdiv_sync u_clkdiv_sync (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ratio_m1(cfg_ratio_m1),
        .cfg_sync_en(cfg_sync_en), .cfg_sync_once(cfg_sync_once),
        .cfg_dcs_req(cfg_dcs_req), .sync_in(sync_in), .ce_out(ce_out),
        .div_out(div_out), .dcs_en(dcs_en), .sync_seen(sync_seen)
    );

    clkdiv_sync u_clkdiv_sync_b (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we_b), .cfg_ratio_m1(cfg_ratio_m1),
        .cfg_sync_en(cfg_sync_en), .cfg_sync_once(cfg_sync_once),
        .cfg_dcs_req(cfg_dcs_req), .sync_in(sync_in), .ce_out(ce_b),
        .div_out(div_b), .dcs_en(dcs_b), .sync_seen(seen_b)
    );

    // Vector: {ratio_m1[6:4], floor(N/2)[3:1], expected dcs_en[0]}
    localparam logic [6:0] VEC [8] = '{
        {3'd3, 3'd2, 1'b1}, {3'd0, 3'd0, 1'b0}, {3'd6, 3'd3, 1'b1},
        {3'd1, 3'd1, 1'b1}, {3'd7, 3'd4, 1'b1}, {3'd2, 3'd1, 1'b1},
        {3'd5, 3'd3, 1'b1}, {3'd4, 3'd2, 1'b1}
    };

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_a(input logic [2:0] r, input logic se, input logic so, input logic dq);
        cfg_ratio_m1 = r; cfg_sync_en = se; cfg_sync_once = so; cfg_dcs_req = dq;
        cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wait_ce();
        int guard = 0;
        do begin
            @(negedge clk);
            guard++;
        end while (!ce_out && guard < 20);
    endtask

    // Starts on a negedge with ce_out high; returns offset of next pulse.
    task automatic probe(output int off);
        off = 0;
        sync_in = 1'b1;
        for (int k = 1; k <= 20; k++) begin
            @(negedge clk);
            if (k == 1) sync_in = 1'b0;
            if (ce_out && off == 0) off = k;
        end
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        n_chk++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int off, mis_ce, mis_dv, t1, t2, diff;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check("R11 ce_out", int'(ce_out), 1);
        check("R11 div_out", int'(div_out), 0);
        check("R11 dcs_en", int'(dcs_en), 0);
        check("R11 sync_seen", int'(sync_seen), 0);

        // R1 R2 R3 R4 R6: per-ratio pattern after an accepted strobe
        foreach (VEC[v]) begin
            int n, h;
            n = int'(VEC[v][6:4]) + 1;
            h = int'(VEC[v][3:1]);
            write_a(VEC[v][6:4], 1'b1, 1'b0, 1'b0);
            repeat (3) @(negedge clk);
            sync_in = 1'b1;
            @(negedge clk); sync_in = 1'b0;
            @(negedge clk); @(negedge clk);
            mis_ce = 0; mis_dv = 0;
            for (int i = 0; i < 2 * n; i++) begin
                if (ce_out != ((i % n) == n - 1)) mis_ce++;
                if (div_out != ((i % n) < h)) mis_dv++;
                if (i == 0) check("R3 dcs_en per ratio", int'(dcs_en), int'(VEC[v][0]));
                @(negedge clk);
            end
            check("R1 R4 ce_out pattern mismatches", mis_ce, 0);
            check("R2 div_out pattern mismatches", mis_dv, 0);
        end

        // R3: ratio 1 with request bit set
        write_a(3'd0, 1'b0, 1'b0, 1'b1);
        repeat (2) @(negedge clk);
        check("R3 dcs_en req at N=1", int'(dcs_en), 1);

        // R5: strobe ignored when disabled (N=4)
        write_a(3'd3, 1'b0, 1'b0, 1'b0);
        wait_ce(); wait_ce();
        probe(off);
        check("R5 strobe ignored offset", off, 4);

        // R6: every-edge mode accepts repeated strobes
        write_a(3'd3, 1'b1, 1'b0, 1'b0);
        wait_ce(); wait_ce();
        probe(off);
        check("R6 first strobe offset", off, 6);
        wait_ce();
        probe(off);
        check("R6 second strobe offset", off, 6);

        // R7 R9: one-shot mode
        write_a(3'd3, 1'b1, 1'b1, 1'b0);
        check("R9 seen cleared by write", int'(sync_seen), 0);
        wait_ce(); wait_ce();
        probe(off);
        check("R7 armed strobe offset", off, 6);
        check("R9 seen after one-shot", int'(sync_seen), 1);
        wait_ce();
        probe(off);
        check("R7 disarmed strobe offset", off, 4);
        write_a(3'd3, 1'b1, 1'b1, 1'b0);
        check("R9 seen cleared again", int'(sync_seen), 0);
        wait_ce(); wait_ce();
        probe(off);
        check("R7 rearmed strobe offset", off, 6);

        // R8: ratio change 4 -> 6 at a wrap, sync disabled
        write_a(3'd3, 1'b0, 1'b0, 1'b0);
        wait_ce(); wait_ce();
        cfg_ratio_m1 = 3'd5; cfg_we = 1'b1;
        t1 = 0; t2 = 0;
        for (int k = 1; k <= 16; k++) begin
            @(negedge clk);
            if (k == 1) cfg_we = 1'b0;
            if (ce_out && t1 == 0) t1 = k;
            else if (ce_out && t2 == 0) t2 = k;
        end
        check("R8 old period completes", t1, 4);
        check("R8 new period length", t2 - t1, 6);

        // R10: two dividers brought into step
        write_a(3'd4, 1'b1, 1'b0, 1'b0);
        repeat (2) @(negedge clk);
        cfg_we_b = 1'b1;
        @(negedge clk);
        cfg_we_b = 1'b0;
        repeat (6) @(negedge clk);
        diff = 0;
        for (int i = 0; i < 10; i++) begin
            if (ce_out != ce_b) diff++;
            @(negedge clk);
        end
        check("R10 phases differ before strobe", int'(diff > 0), 1);
        sync_in = 1'b1;
        @(negedge clk); sync_in = 1'b0;
        @(negedge clk); @(negedge clk);
        mis_ce = 0;
        for (int i = 0; i < 20; i++) begin
            if (ce_out != ce_b || div_out != div_b) mis_ce++;
            if (ce_out != ((i % 5) == 4)) mis_ce++;
            @(negedge clk);
        end
        check("R10 aligned outputs mismatches", mis_ce, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule